// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Port

The block is a byte-wide synchronous serial port that acts as either the clock-driving side or the clock-following side of an SPI link. A host reaches it through a small register interface with two locations. Address 0 is a control register that sets the operating mode, the clock idle level and the enable bit, and that holds two sticky error flags. Address 1 is the data buffer: a write queues a byte for transmission, and a read returns the last byte received.

In master mode the port makes SCK from the system clock, using one of three fixed dividers, or from an external timer tick. Writing the buffer starts a transfer. In slave mode SCK, slave select and SDI come from outside. They are resynchronised to the system clock, and the port shifts on the detected edges. Each byte goes out MSB first. The transmitting side changes SDO on the edge that leaves the idle level, and the receiving side samples SDI on the edge that returns to it. A finished byte moves from the shift register into the receive buffer, sets a buffer-full status and raises a one-cycle completion pulse.

Top module: `spiPort`

## Requirements
- R1: After reset the control register reads 0x00, SCK is low, SDO and its output enable are 0, and both buffer-full and the completion pulse are 0.
- R2: Control register at address 0, bit 7 = write-collision flag, bit 6 = receive-overflow flag, bit 5 = enable, bit 4 = clock idle level, bits 3:0 = mode. Bits 5:0 read back as written. Writing 0 to a flag clears it, and writing 1 leaves it unchanged. Address 1 is the data buffer.
- R3: Mode 0000, 0001 and 0010 are master modes with an SCK period of 4, 16 and 64 system clocks, so a byte completes 32, 128 and 512 cycles after the buffer write. In mode 0011 SCK toggles once per timer tick.
- R4: With the idle-level bit at 1, SCK rests high between transfers. With the bit at 0, SCK rests low.
- R5: Data moves MSB first in both directions at the same time. SDO changes on the edge that leaves the idle level, and SDI is sampled on the edge that returns to it.
- R6: When a byte completes, the completion pulse is high for exactly one cycle, the received byte appears at address 1 and buffer-full sets. A host read of address 1 clears buffer-full.
- R7: In mode 0100 a high slave select stops all shifting, clears any partial byte and drops the SDO output enable. A low slave select raises the output enable.
- R8: In mode 0101 slave select has no effect: bytes transfer and SDO stays enabled while it is high.
- R9: In a slave mode, a byte that completes while buffer-full is set is discarded, the buffer keeps its old byte and the overflow flag sets.
- R10: In a master mode the overflow flag never sets. A new byte replaces an unread one.
- R11: A buffer write during a transfer sets the collision flag. The write is dropped, and the transfer in progress continues unchanged.
- R12: With enable at 0, or with a mode code other than 0000 to 0101, SCK sits at the idle level, SDO and its enable are 0, and buffer writes start nothing.
- R13: If a byte completes in the same cycle as a host read of the buffer, the read returns the old byte, the new byte is stored, buffer-full stays set and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Host register write strobe |
| regRd | input | 1 | Host register read strobe |
| regAddr | input | 1 | 0 = control register, 1 = data buffer |
| wrData | input | DATA_W | Host write data |
| rdData | output | DATA_W | Host read data for the selected address |
| bufFull | output | 1 | Receive buffer holds an unread byte |
| xferDone | output | 1 | One-cycle pulse when a byte completes |
| tickIn | input | 1 | External timer tick for the timer-clocked master mode |
| sckOut | output | 1 | Serial clock driven in master mode |
| sdo | output | 1 | Serial data out |
| sdoEn | output | 1 | Output enable for sdo |
| sckIn | input | 1 | Serial clock from outside in slave mode |
| sdi | input | 1 | Serial data in |
| ssN | input | 1 | Active-low slave select |

## Verification
A byte can finish in the same cycle that the host reads the buffer, so the logic that clears buffer-full and the logic that fills the buffer both act on the same edge. With the fastest master divider the completion cycle is known exactly: it is the 32nd edge after the buffer write. The bench leaves one byte unread, starts a second transfer and raises the read strobe for exactly that edge. It then checks that the read returned the first byte, that buffer-full stayed set with the second byte stored, and that the overflow flag stayed clear.

// File: rtl/spiPkg.sv
`timescale 1ns/1ps
package spiPkg;
  localparam int CTRL_W = 8;

  localparam logic [3:0] MODE_SLAVE_SEL  = 4'b0100;
  localparam logic [3:0] MODE_SLAVE_FREE = 4'b0101;
  localparam logic [1:0] RATE_TIMER      = 2'b11;

  typedef struct packed {
    logic load;    // take host byte into the shift register
    logic lead;    // edge leaving idle: drive next bit
    logic trail;   // edge returning to idle: sample input
    logic commit;  // accepted byte goes to the receive buffer
    logic clear;   // port idle: drop partial byte
  } spiStrobeT;
endpackage

// File: rtl/spiData.sv
`timescale 1ns/1ps
module spiData
  import spiPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobeT         strb,
  input  logic [DATA_W-1:0] hostData,
  input  logic              sdi,
  output logic              sdoBit,
  output logic [DATA_W-1:0] rxBuf,
  output logic              lastBit
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] nextShift;

  assign lastBit   = (bitCnt == CNT_W'(DATA_W - 1));
  assign nextShift = {shiftReg[DATA_W-2:0], sdi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxBuf    <= '0;
      bitCnt   <= '0;
      sdoBit   <= 1'b0;
    end else if (strb.clear) begin
      bitCnt <= '0;
      sdoBit <= 1'b0;
    end else begin
      if (strb.load) shiftReg <= hostData;
      if (strb.lead) sdoBit <= strb.load ? hostData[DATA_W-1] : shiftReg[DATA_W-1];
      if (strb.trail) begin
        shiftReg <= nextShift;
        bitCnt   <= lastBit ? '0 : bitCnt + 1'b1;
      end
      if (strb.commit) rxBuf <= nextShift;
    end
  end

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.lead && strb.trail)); // R5
  AST_COMMIT_ON_LAST: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (strb.trail && lastBit)); // R6
endmodule

// File: rtl/spiCtrl.sv
`timescale 1ns/1ps
module spiCtrl
  import spiPkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              regAddr,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              tickIn,
  input  logic              sckIn,
  input  logic              ssN,
  input  logic              lastBit,
  output spiStrobeT         strb,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic              bufFull,
  output logic              xferDone,
  output logic              sckOut,
  output logic              sdoEn
);
  localparam int DIV_W = $clog2(DIV_C / 2) + 1;
  localparam logic [DIV_W-1:0] LIM_A = DIV_W'(DIV_A / 2 - 1);
  localparam logic [DIV_W-1:0] LIM_B = DIV_W'(DIV_B / 2 - 1);
  localparam logic [DIV_W-1:0] LIM_C = DIV_W'(DIV_C / 2 - 1);

  logic wcol, ovf, enable, ckp;
  logic [3:0] mode;
  logic isMaster, isSlave, portOn, ssIdle;
  logic ctrlWr, bufWr, bufRd;
  logic active, phase, mTick, sLead, sTrail, lead, trail, commit, store;
  logic [DIV_W-1:0] divCnt, halfLim;
  logic [2:0] sckSy;
  logic [1:0] ssSy;

  assign ctrlReg  = {wcol, ovf, enable, ckp, mode};
  assign isMaster = enable && (mode[3:2] == 2'b00);
  assign isSlave  = enable && ((mode == MODE_SLAVE_SEL) || (mode == MODE_SLAVE_FREE));
  assign portOn   = isMaster || isSlave;
  assign ssIdle   = isSlave && (mode == MODE_SLAVE_SEL) && ssSy[1];

  assign ctrlWr = regWr && !regAddr;
  assign bufWr  = regWr && regAddr && portOn;
  assign bufRd  = regRd && regAddr;

  // master clock generation
  always_comb begin
    case (mode[1:0])
      2'b00:   halfLim = LIM_A;
      2'b01:   halfLim = LIM_B;
      default: halfLim = LIM_C;
    endcase
  end
  assign mTick = isMaster && active &&
                 ((mode[1:0] == RATE_TIMER) ? tickIn : (divCnt == halfLim));

  // slave edge detection on resynchronised SCK
  assign sLead  = isSlave && !ssIdle && (sckSy[2] == ckp) && (sckSy[1] != ckp);
  assign sTrail = isSlave && !ssIdle && active && (sckSy[2] != ckp) && (sckSy[1] == ckp);

  assign lead   = isMaster ? (mTick && !phase) : sLead;
  assign trail  = isMaster ? (mTick && phase)  : sTrail;
  assign commit = trail && lastBit;
  assign store  = isMaster || !bufFull || bufRd;

  assign strb.load   = bufWr && !active;
  assign strb.lead   = lead;
  assign strb.trail  = trail;
  assign strb.commit = commit && store;
  assign strb.clear  = !portOn || ssIdle;

  assign sckOut = ckp ^ (isMaster && phase);
  assign sdoEn  = isMaster || (isSlave && !ssIdle);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSy <= '0;
      ssSy  <= 2'b11;
    end else begin
      sckSy <= {sckSy[1:0], sckIn};
      ssSy  <= {ssSy[0], ssN};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      phase  <= 1'b0;
      divCnt <= '0;
    end else begin
      if (strb.clear || commit)              active <= 1'b0;
      else if (isMaster && strb.load)        active <= 1'b1;
      else if (isSlave && sLead)             active <= 1'b1;

      if (!isMaster || !active)              phase <= 1'b0;
      else if (mTick)                        phase <= ~phase;

      if (!isMaster || !active || mTick)     divCnt <= '0;
      else if (mode[1:0] != RATE_TIMER)      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wcol     <= 1'b0;
      ovf      <= 1'b0;
      enable   <= 1'b0;
      ckp      <= 1'b0;
      mode     <= '0;
      bufFull  <= 1'b0;
      xferDone <= 1'b0;
    end else begin
      if (ctrlWr) begin
        wcol   <= wcol & wrData[7];
        ovf    <= ovf & wrData[6];
        enable <= wrData[5];
        ckp    <= wrData[4];
        mode   <= wrData[3:0];
      end
      if (bufWr && active)   wcol <= 1'b1;
      if (commit && !store)  ovf  <= 1'b1;
      if (commit && store)   bufFull <= 1'b1;
      else if (bufRd)        bufFull <= 1'b0;
      xferDone <= commit;
    end
  end

  AST_MASTER_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !ovf) |=> !ovf); // R10
  AST_SLAVE_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (isSlave && commit && bufFull && !bufRd) |=> ovf); // R9
  AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (wcol && !(ctrlWr && !wrData[7])) |=> wcol); // R11
  AST_SS_HALT: assert property (@(posedge clk) disable iff (!rstN)
    ssIdle |=> !active); // R7
  AST_IDLE_STOP: assert property (@(posedge clk) disable iff (!rstN)
    !portOn |=> (!active && !xferDone)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone); // R6
endmodule

// File: rtl/spiPort.sv
`timescale 1ns/1ps
module spiPort
  import spiPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              bufFull,
  output logic              xferDone,
  input  logic              tickIn,
  output logic              sckOut,
  output logic              sdo,
  output logic              sdoEn,
  input  logic              sckIn,
  input  logic              sdi,
  input  logic              ssN
);
  spiStrobeT         strb;
  logic [CTRL_W-1:0] ctrlReg;
  logic [DATA_W-1:0] rxBuf;
  logic              lastBit, sdoBit;

  spiCtrl #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .wrData(wrData[CTRL_W-1:0]), .tickIn(tickIn), .sckIn(sckIn), .ssN(ssN),
    .lastBit(lastBit), .strb(strb), .ctrlReg(ctrlReg), .bufFull(bufFull),
    .xferDone(xferDone), .sckOut(sckOut), .sdoEn(sdoEn)
  );

  spiData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .hostData(wrData), .sdi(sdi),
    .sdoBit(sdoBit), .rxBuf(rxBuf), .lastBit(lastBit)
  );

  assign rdData = regAddr ? rxBuf : DATA_W'(ctrlReg);
  assign sdo    = sdoBit && sdoEn;
endmodule

// File: tb/spiPort_bench.sv
`timescale 1ns/1ps
module spiPort_bench;
  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0, regRd = 1'b0, regAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic bufFull, xferDone, sckOut, sdo, sdoEn;
  logic tickIn = 1'b0, sckIn = 1'b0, sdi = 1'b0, ssN = 1'b1;

  int nTests = 0, nFails = 0;

  logic [7:0] periTx = '0, periRx = '0;
  logic periCkp = 1'b0, periOn = 1'b0, lastSck = 1'b0, tickOn = 1'b0;
  int tickCnt = 0;

  spiPort u_spiPort (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .bufFull(bufFull), .xferDone(xferDone),
    .tickIn(tickIn), .sckOut(sckOut), .sdo(sdo), .sdoEn(sdoEn),
    .sckIn(sckIn), .sdi(sdi), .ssN(ssN)
  );

  always #4 clk = ~clk;

  // bench-side peer for master transfers
  always @(negedge clk) begin
    if (periOn && (sckOut != lastSck)) begin
      if (sckOut != periCkp) begin
        sdi    = periTx[7];
        periTx = {periTx[6:0], 1'b0};
      end else begin
        periRx = {periRx[6:0], sdo};
      end
    end
    lastSck = sckOut;
  end

  always @(negedge clk) begin
    tickCnt++;
    tickIn = tickOn && (tickCnt % 3 == 0);
  end

  function automatic int expCycles(input logic [1:0] rate);
    case (rate)
      2'd0:    return 8 * 4;
      2'd1:    return 8 * 16;
      default: return 8 * 64;
    endcase
  endfunction

  function automatic logic [7:0] ctrlWord(input logic en, input logic ckpV, input logic [3:0] m);
    return {2'b00, en, ckpV, m};
  endfunction

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic a, input logic [7:0] d);
    regAddr = a; wrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [7:0] v);
    regAddr = a; regRd = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic masterXfer(input logic [3:0] m, input logic ckpV,
                            input logic [7:0] tx, input logic [7:0] pb, output int cyc);
    periCkp = ckpV;
    writeReg(1'b0, ctrlWord(1'b1, ckpV, m));
    @(negedge clk);
    periTx = pb; periRx = '0; periOn = 1'b1;
    writeReg(1'b1, tx);
    cyc = 0;
    while (!xferDone && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    periOn = 1'b0;
  endtask

  task automatic slaveXfer(input logic ckpV, input logic [7:0] pb, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      sckIn = ~ckpV; sdi = pb[i];
      repeat (6) @(negedge clk);
      got[i] = sdo;
      sckIn = ckpV;
      repeat (6) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFails++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    logic [7:0] v, got, tx, pb;
    logic ck;
    logic [1:0] rate;
    int cyc;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    // R1 reset state
    readReg(1'b0, v);
    chk("R1 ctrl", v, 8'h00);
    chk("R1 sck", sckOut, 0);
    chk("R1 sdoEn", sdoEn, 0);
    chk("R1 bufFull", bufFull, 0);
    chk("R1 done", xferDone, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 layout and flag write rules
    writeReg(1'b0, 8'hD5);
    readReg(1'b0, v);
    chk("R2 readback, flags not set by 1", v, 8'h15);

    // R12 disabled port with idle high
    writeReg(1'b0, ctrlWord(1'b0, 1'b1, 4'b0000));
    writeReg(1'b1, 8'hA5);
    repeat (40) @(negedge clk);
    chk("R12 disabled sck", sckOut, 1);
    chk("R12 disabled sdoEn", sdoEn, 0);
    chk("R12 disabled no xfer", bufFull, 0);
    // R12 reserved mode code
    writeReg(1'b0, ctrlWord(1'b1, 1'b0, 4'b0110));
    writeReg(1'b1, 8'h3C);
    repeat (40) @(negedge clk);
    chk("R12 reserved sck", sckOut, 0);
    chk("R12 reserved sdo", {sdoEn, sdo}, 0);
    chk("R12 reserved no xfer", bufFull, 0);

    // R3 R5 R6 directed master, each divider
    for (int r = 0; r < 3; r++) begin
      masterXfer(4'(r), 1'b0, 8'h96, 8'h5A, cyc);
      chk("R3 master cycles", cyc, expCycles(2'(r)));
      chk("R5 master tx", periRx, 8'h96);
      chk("R6 bufFull set", bufFull, 1);
      chk("R6 done one cycle", xferDone, 0);
      readReg(1'b1, v);
      chk("R6 master rx", v, 8'h5A);
      chk("R6 read clears", bufFull, 0);
    end

    // R4 idle high clock
    writeReg(1'b0, ctrlWord(1'b1, 1'b1, 4'b0000));
    @(negedge clk);
    chk("R4 idle high", sckOut, 1);
    masterXfer(4'b0000, 1'b1, 8'h81, 8'h7E, cyc);
    chk("R4 tx ckp1", periRx, 8'h81);
    chk("R4 idle after", sckOut, 1);
    readReg(1'b1, v);
    chk("R4 rx ckp1", v, 8'h7E);

    // R3 timer-clocked master
    tickOn = 1'b1;
    masterXfer(4'b0011, 1'b0, 8'hC3, 8'h24, cyc);
    tickOn = 1'b0;
    chk("R3 timer span", (cyc >= 44 && cyc <= 52) ? 1 : 0, 1);
    chk("R3 timer tx", periRx, 8'hC3);
    readReg(1'b1, v);
    chk("R3 timer rx", v, 8'h24);

    // R10 R13: unread byte, then completion on the read edge
    masterXfer(4'b0000, 1'b0, 8'h11, 8'hE1, cyc);
    periTx = 8'h3B; periRx = '0; periOn = 1'b1;
    writeReg(1'b1, 8'h22);
    repeat (31) @(negedge clk);
    regAddr = 1'b1; regRd = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    regRd = 1'b0;
    chk("R13 read old byte", v, 8'hE1);
    chk("R13 completion same edge", xferDone, 1);
    chk("R13 bufFull kept", bufFull, 1);
    @(negedge clk);
    periOn = 1'b0;
    readReg(1'b1, v);
    chk("R13 new byte stored", v, 8'h3B);
    masterXfer(4'b0000, 1'b0, 8'h44, 8'h90, cyc);
    masterXfer(4'b0000, 1'b0, 8'h55, 8'h0F, cyc);
    readReg(1'b0, v);
    chk("R10 master no overflow", v[6], 0);
    readReg(1'b1, v);
    chk("R10 master replaces", v, 8'h0F);

    // R11 collision in master
    periCkp = 1'b0;
    writeReg(1'b0, ctrlWord(1'b1, 1'b0, 4'b0001));
    @(negedge clk);
    periTx = 8'h6D; periRx = '0; periOn = 1'b1;
    writeReg(1'b1, 8'hA7);
    repeat (10) @(negedge clk);
    writeReg(1'b1, 8'h18);
    readReg(1'b0, v);
    chk("R11 wcol set", v[7], 1);
    repeat (140) @(negedge clk);
    periOn = 1'b0;
    chk("R11 transfer unchanged", periRx, 8'hA7);
    writeReg(1'b0, 8'hA1);
    readReg(1'b0, v);
    chk("R11 wcol kept by 1", v[7], 1);
    writeReg(1'b0, 8'h21);
    readReg(1'b0, v);
    chk("R2 wcol cleared by 0", v, 8'h21);
    readReg(1'b1, v);

    // Slave with select honoured
    sckIn = 1'b0; ssN = 1'b0;
    writeReg(1'b0, ctrlWord(1'b1, 1'b0, 4'b0100));
    repeat (4) @(negedge clk);
    chk("R7 sdoEn when selected", sdoEn, 1);
    writeReg(1'b1, 8'hB4);
    slaveXfer(1'b0, 8'h63, got);
    chk("R5 slave tx", got, 8'hB4);
    chk("R6 slave bufFull", bufFull, 1);
    readReg(1'b1, v);
    chk("R6 slave rx", v, 8'h63);

    // R7 deselected: ignored
    ssN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 sdoEn dropped", sdoEn, 0);
    slaveXfer(1'b0, 8'hFF, got);
    chk("R7 no byte while deselected", bufFull, 0);
    ssN = 1'b0;
    repeat (4) @(negedge clk);

    // R9 overflow
    slaveXfer(1'b0, 8'h4E, got);
    slaveXfer(1'b0, 8'hD2, got);
    readReg(1'b0, v);
    chk("R9 overflow flag", v[6], 1);
    writeReg(1'b0, 8'h64);
    readReg(1'b0, v);
    chk("R2 ovf kept by 1", v[6], 1);
    readReg(1'b1, v);
    chk("R9 old byte kept", v, 8'h4E);
    writeReg(1'b0, 8'h24);
    readReg(1'b0, v);
    chk("R2 ovf cleared by 0", v[6], 0);

    // R8 select ignored, idle high clock
    sckIn = 1'b1; ssN = 1'b1;
    writeReg(1'b0, ctrlWord(1'b1, 1'b1, 4'b0101));
    repeat (4) @(negedge clk);
    chk("R8 sdoEn while ss high", sdoEn, 1);
    writeReg(1'b1, 8'h2D);
    slaveXfer(1'b1, 8'hC9, got);
    chk("R8 tx with ss high", got, 8'h2D);
    readReg(1'b1, v);
    chk("R8 rx with ss high", v, 8'hC9);

    // random master transfers
    for (int k = 0; k < 16; k++) begin
      tx = 8'($urandom); pb = 8'($urandom);
      rate = 2'($urandom % 3); ck = 1'($urandom);
      masterXfer({2'b00, rate}, ck, tx, pb, cyc);
      chk("R3 random cycles", cyc, expCycles(rate));
      chk("R5 random tx", periRx, tx);
      readReg(1'b1, v);
      chk("R6 random rx", v, pb);
    end

    // random slave transfers
    ssN = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tx = 8'($urandom); pb = 8'($urandom); ck = 1'($urandom);
      sckIn = ck;
      writeReg(1'b0, ctrlWord(1'b1, ck, 4'b0100));
      repeat (4) @(negedge clk);
      writeReg(1'b1, tx);
      slaveXfer(ck, pb, got);
      chk("R5 random slave tx", got, tx);
      readReg(1'b1, v);
      chk("R6 random slave rx", v, pb);
    end

    report();
  end
endmodule